// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O port with up to 32 pins, attached to a simple single-cycle register bus. Software controls the output levels and the per-pin output enables through a data register and a direction register. Software reads the actual pin levels through a read-only port view. That view passes through a synchroniser, so it shows the pads and not the value last written.

Each pin also has interrupt detection. A type bit chooses level or edge detection, and a polarity bit chooses high/rising or low/falling. Each pin has an enable bit. Edge events are held until software writes a mask to an end-of-interrupt register. Level conditions follow the synchronised pin. All enabled pending bits are ORed onto a single interrupt line.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, pin_oe and pin_out are all zero and irq_o is low.
- R2: The data register at offset 0x00 drives pin_out. The direction register at offset 0x04 drives pin_oe, where a 1 makes the pin an output. Both read back what was written.
- R3: The port view at offset 0x44 returns pin_in after a two-flop synchroniser, not the data register. A change is visible two clock edges after it appears at the pin, and not after one.
- R4: When the type bit (offset 0x34) is 1 and the polarity bit (offset 0x38) is 1, a 0-to-1 transition on an enabled pin sets its status bit. The bit stays set after the pin returns low.
- R5: When the type bit is 1 and the polarity bit is 0, only a 1-to-0 transition sets the status bit. A rising transition leaves it clear.
- R6: When the type bit is 0, the status bit equals 1 exactly while the synchronised pin equals the polarity bit (1 means high active, 0 means low active).
- R7: A pin whose enable bit (offset 0x30) is 0 never shows a set status bit and never drives irq_o. An edge that occurs while the pin is disabled is not latched and does not appear when the pin is enabled later.
- R8: Writing a mask to offset 0x40 clears the latched edge status bits at the positions set in the mask and leaves other bits unchanged. A level status bit whose level is still active stays set.
- R9: The status register (offset 0x3C) reads the enabled pending bits, and irq_o is high exactly when any status bit is set.
- R10: Reads of offset 0x40 and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong synchroniser depth shows up one cycle early or late on the port view. It also shifts every status change by the same amount. A lost or stuck edge latch shows up on the status register and on irq_o within three cycles of the pin transition. It persists until an end-of-interrupt write, so a clear that misses its bit or hits a neighbouring bit is caught on the very next status read. Detection with the wrong polarity or type is caught by driving the opposite transition first and checking that the status stays clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Register byte offsets. The control window starts at 0x30.
   localparam int unsigned OFF_DATA   = 'h00;
   localparam int unsigned OFF_DIR    = 'h04;
   localparam int unsigned OFF_IRQEN  = 'h30;
   localparam int unsigned OFF_TYPE   = 'h34;
   localparam int unsigned OFF_POL    = 'h38;
   localparam int unsigned OFF_STATUS = 'h3C;
   localparam int unsigned OFF_EOI    = 'h40;
   localparam int unsigned OFF_PORT   = 'h44;

   localparam int unsigned BUS_DW     = 32;
   localparam int unsigned MIN_ADDR_W = 7;

   typedef logic [BUS_DW-1:0] bus_word_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= din;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] en,
   input  logic [W-1:0] edge_sel,
   input  logic [W-1:0] pol,
   input  logic         eoi_valid,
   input  logic [W-1:0] eoi_mask,
   output logic [W-1:0] evt,
   output logic [W-1:0] latch,
   output logic [W-1:0] status
);

   for (genvar i = 0; i < int'(W); i++) begin : g_pin
      logic prev_q;
      logic latch_q;
      logic level_hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[i];
      end

      assign evt[i] = edge_sel[i] &
                      (pol[i] ? (lvl[i] & ~prev_q) : (~lvl[i] & prev_q));

      // a new event wins over a clear arriving in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         latch_q <= 1'b0;
         else if (evt[i] && en[i])           latch_q <= 1'b1;
         else if (eoi_valid && eoi_mask[i])  latch_q <= 1'b0;
      end

      assign level_hit = ~edge_sel[i] & (lvl[i] ~^ pol[i]);
      assign latch[i]  = latch_q;
      assign status[i] = en[i] & (edge_sel[i] ? latch_q : level_hit);
   end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_irq_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  bus_word_t         bus_wdata,
   output bus_word_t         bus_rdata,
   input  logic [W-1:0]      lvl,
   input  logic [W-1:0]      status,
   output logic [W-1:0]      data_q,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      en_q,
   output logic [W-1:0]      type_q,
   output logic [W-1:0]      pol_q,
   output logic              eoi_valid,
   output logic [W-1:0]      eoi_mask
);

   logic wr_en;
   assign wr_en = bus_sel & bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         en_q   <= '0;
         type_q <= '0;
         pol_q  <= '0;
      end else if (wr_en) begin
         if (bus_addr == ADDR_W'(OFF_DATA))  data_q <= bus_wdata[W-1:0];
         if (bus_addr == ADDR_W'(OFF_DIR))   dir_q  <= bus_wdata[W-1:0];
         if (bus_addr == ADDR_W'(OFF_IRQEN)) en_q   <= bus_wdata[W-1:0];
         if (bus_addr == ADDR_W'(OFF_TYPE))  type_q <= bus_wdata[W-1:0];
         if (bus_addr == ADDR_W'(OFF_POL))   pol_q  <= bus_wdata[W-1:0];
      end
   end

   assign eoi_valid = wr_en && (bus_addr == ADDR_W'(OFF_EOI));
   assign eoi_mask  = bus_wdata[W-1:0];

   logic [W-1:0] sel_val;

   always_comb begin
      sel_val = '0;
      if (bus_sel && !bus_wr) begin
         if      (bus_addr == ADDR_W'(OFF_DATA))   sel_val = data_q;
         else if (bus_addr == ADDR_W'(OFF_DIR))    sel_val = dir_q;
         else if (bus_addr == ADDR_W'(OFF_IRQEN))  sel_val = en_q;
         else if (bus_addr == ADDR_W'(OFF_TYPE))   sel_val = type_q;
         else if (bus_addr == ADDR_W'(OFF_POL))    sel_val = pol_q;
         else if (bus_addr == ADDR_W'(OFF_STATUS)) sel_val = status;
         else if (bus_addr == ADDR_W'(OFF_PORT))   sel_val = lvl;
         else                                      sel_val = '0;
      end
      bus_rdata        = '0;
      bus_rdata[W-1:0] = sel_val;
   end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq_o
);

   if (NPINS < 1 || NPINS > BUS_DW) begin : g_bad_npins
      $error("gpio_irq_port: NPINS must be 1..32");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("gpio_irq_port: ADDR_W too narrow for the control window");
   end

   logic [NPINS-1:0] lvl_sync;
   logic [NPINS-1:0] data_q, dir_q, en_q, type_q, pol_q;
   logic [NPINS-1:0] eoi_mask, edge_evt, edge_latch, status;
   logic             eoi_valid;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (lvl_sync)
   );

   gpio_regfile #(.W(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .lvl      (lvl_sync),
      .status   (status),
      .data_q   (data_q),
      .dir_q    (dir_q),
      .en_q     (en_q),
      .type_q   (type_q),
      .pol_q    (pol_q),
      .eoi_valid(eoi_valid),
      .eoi_mask (eoi_mask)
   );

   gpio_irq_detect #(.W(NPINS)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_sync),
      .en       (en_q),
      .edge_sel (type_q),
      .pol      (pol_q),
      .eoi_valid(eoi_valid),
      .eoi_mask (eoi_mask),
      .evt      (edge_evt),
      .latch    (edge_latch),
      .status   (status)
   );

   assign pin_out = data_q;
   assign pin_oe  = dir_q;
   assign irq_o   = |status;

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe,
   input logic              irq_o,
   input logic [NPINS-1:0]  en_q,
   input logic [NPINS-1:0]  edge_evt,
   input logic [NPINS-1:0]  edge_latch
);

   // R2
   data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_DATA))
      |=> (pin_out == $past(bus_wdata[NPINS-1:0])));

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_DIR))
      |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));

   // R4
   edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(edge_evt & en_q))
      |=> ((edge_latch & $past(edge_evt & en_q)) == $past(edge_evt & en_q)));

   // R8
   eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_EOI))
      |=> ((edge_latch & $past(bus_wdata[NPINS-1:0]) & ~$past(edge_evt & en_q)) == '0));

   // R9
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|en_q));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_o     (irq_o),
   .en_q      (en_q),
   .edge_evt  (edge_evt),
   .edge_latch(edge_latch)
);

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;

   localparam int NP = 32;
   localparam logic [7:0] A_DATA = 8'h00, A_DIR = 8'h04, A_EN = 8'h30, A_TYPE = 8'h34,
                          A_POL = 8'h38, A_STAT = 8'h3C, A_EOI = 8'h40, A_PORT = 8'h44;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] en_v = '0, type_v = '0, pol_v = '0;

   always #10 clk = ~clk;

   gpio_irq_port u_gpio_irq_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(A_DATA, v); check("R1 data", v, 0);
      rd(A_DIR,  v); check("R1 dir", v, 0);
      rd(A_EN,   v); check("R1 enable", v, 0);
      rd(A_TYPE, v); check("R1 type", v, 0);
      rd(A_POL,  v); check("R1 polarity", v, 0);
      rd(A_STAT, v); check("R1 status", v, 0);
      check("R1 pin_oe", pin_oe, 0);
      check("R1 pin_out", pin_out, 0);
      check("R1 irq", {31'b0, irq_o}, 0);
   endtask

   task automatic t_outputs;
      logic [31:0] v;
      wr(A_DATA, 32'hA5A5_0F0F);
      check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
      wr(A_DIR, 32'hFFFF_0000);
      check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
      rd(A_DATA, v); check("R2 data readback", v, 32'hA5A5_0F0F);
      rd(A_DIR, v);  check("R2 dir readback", v, 32'hFFFF_0000);
      pin_in = 32'h1234_5678;
      rd(A_PORT, v); check("R3 one edge still old", v, 0);
      rd(A_PORT, v); check("R3 two edges new level", v, 32'h1234_5678);
      pin_in = '0;
      tick(4);
      rd(A_PORT, v); check("R3 port back to zero", v, 0);
   endtask

   task automatic t_rise;
      logic [31:0] v;
      type_v[0] = 1'b1; pol_v[0] = 1'b1; en_v[0] = 1'b1;
      wr(A_TYPE, type_v); wr(A_POL, pol_v); wr(A_EN, en_v);
      rd(A_STAT, v); check("R4 idle status", v, 0);
      pin_in[0] = 1'b1; tick(3);
      rd(A_STAT, v); check("R4 rising latched", v, 32'h1);
      check("R9 irq on edge", {31'b0, irq_o}, 1);
      pin_in[0] = 1'b0; tick(3);
      rd(A_STAT, v); check("R4 held after pin low", v, 32'h1);
      wr(A_EOI, 32'h2);
      rd(A_STAT, v); check("R8 other mask bit keeps latch", v, 32'h1);
      wr(A_EOI, 32'h1);
      rd(A_STAT, v); check("R8 eoi clears", v, 0);
      check("R9 irq drops", {31'b0, irq_o}, 0);
   endtask

   task automatic t_fall;
      logic [31:0] v;
      type_v[1] = 1'b1; pol_v[1] = 1'b0; en_v[1] = 1'b1;
      wr(A_TYPE, type_v); wr(A_POL, pol_v); wr(A_EN, en_v);
      pin_in[1] = 1'b1; tick(3);
      rd(A_STAT, v); check("R5 rising ignored", v, 0);
      pin_in[1] = 1'b0; tick(3);
      rd(A_STAT, v); check("R5 falling latched", v, 32'h2);
      check("R9 irq on fall", {31'b0, irq_o}, 1);
      wr(A_EOI, 32'h2);
      rd(A_STAT, v); check("R8 fall cleared", v, 0);
   endtask

   task automatic t_level;
      logic [31:0] v;
      pol_v[2] = 1'b1; en_v[2] = 1'b1;
      wr(A_POL, pol_v); wr(A_EN, en_v);
      rd(A_STAT, v); check("R6 high level idle", v, 0);
      pin_in[2] = 1'b1; tick(3);
      rd(A_STAT, v); check("R6 high level active", v, 32'h4);
      wr(A_EOI, 32'h4);
      rd(A_STAT, v); check("R8 level not clearable", v, 32'h4);
      pin_in[2] = 1'b0; tick(3);
      rd(A_STAT, v); check("R6 high level released", v, 0);
      en_v[3] = 1'b1;
      wr(A_EN, en_v);
      rd(A_STAT, v); check("R6 low level active", v, 32'h8);
      check("R9 irq on low level", {31'b0, irq_o}, 1);
      pin_in[3] = 1'b1; tick(3);
      rd(A_STAT, v); check("R6 low level released", v, 0);
      check("R9 irq low", {31'b0, irq_o}, 0);
   endtask

   task automatic t_disabled;
      logic [31:0] v;
      type_v[4] = 1'b1; pol_v[4] = 1'b1;
      wr(A_TYPE, type_v); wr(A_POL, pol_v);
      pin_in[4] = 1'b1; tick(3);
      rd(A_STAT, v); check("R7 disabled no status", v, 0);
      check("R7 disabled no irq", {31'b0, irq_o}, 0);
      en_v[4] = 1'b1;
      wr(A_EN, en_v);
      rd(A_STAT, v); check("R7 old edge not latched", v, 0);
      check("R7 irq stays low", {31'b0, irq_o}, 0);
      pin_in[4] = 1'b0; tick(3);
      pin_in[4] = 1'b1; tick(3);
      rd(A_STAT, v); check("R7 enabled edge latched", v, 32'h10);
      wr(A_EOI, 32'h10);
      rd(A_STAT, v); check("R8 cleared bit4", v, 0);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      rd(A_EOI, v); check("R10 eoi reads zero", v, 0);
      rd(8'h08, v); check("R10 unmapped 0x08", v, 0);
      rd(8'h80, v); check("R10 unmapped 0x80", v, 0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_outputs();
      t_rise();
      t_fall();
      t_level();
      t_disabled();
      t_unmapped();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule